// File: doc/BRIEF.md
# Transmit Output Level Controller

This block closes a short digital loop around a transmitter's output level. Two comparator flags report whether the sensed output sits above an upper threshold or below a lower one. The block turns them into a 3-bit code that drives an external stepped attenuator. Code value n selects n × 3 dB of attenuation, so 0 is full level and 7 is −21 dB.

The loop adapts only in a short window that opens after a hard reset, after a soft-reset pulse, or when transmit mode is entered. After the window closes the code is frozen until the next such event. Inside the window each adaptation step takes two clock cycles. In the evaluate cycle the flags are sampled and the new code is registered. The adjust cycle that follows gives the analog path time to settle and ignores the flags. The top control bit bypasses the loop and forces the attenuation to the programmed 3-bit value.

Top module: `tx_alc`

## Requirements
- R1: Flags are sampled only in evaluate cycles. These are the first cycle of an open window and every second cycle after it (window cycles 0, 2, 4, …, 14). Flags present only in the adjust cycles have no effect on the code.
- R2: A step decided in an evaluate cycle shows on `atten` in the very next cycle.
- R3: The window is 16 cycles long, counted from the first cycle after the restart event, and then closes.
- R4: While the window is closed and bypass is clear, the code does not change, whatever the flags do.
- R5: With `lvl_high` = 1 in an evaluate cycle, the code rises by one. It saturates at 7.
- R6: With `lvl_low` = 1 and `lvl_high` = 0 in an evaluate cycle, the code falls by one and saturates at 0. With both flags set, `lvl_high` wins. With neither set, the code holds.
- R7: While `rst_n` is low and after its release, `atten` is 0 and a window is open. The first cycle after release is an evaluate cycle.
- R8: A `soft_rst` pulse, or a 0-to-1 change of `tx_mode`, restarts the window without changing the code. The restart cycle itself takes no step. Holding `tx_mode` high does not restart the window again.
- R9: With `ctrl[3]` = 1, `atten` equals `ctrl[2:0]` in the same cycle.
- R10: Clearing `ctrl[3]` does not reopen a closed window. The loop resumes, on the next restart, from the last forced value.
- R11: `adapt_active` is 1 exactly when the window is open and `ctrl[3]` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | One-cycle soft-reset pulse, restarts the window |
| tx_mode | input | 1 | Transmit mode; a rising edge restarts the window |
| ctrl | input | 4 | Bit 3 bypass; bits 2:0 forced attenuation code |
| lvl_high | input | 1 | Sensed level above the upper threshold |
| lvl_low | input | 1 | Sensed level below the lower threshold |
| atten | output | 3 | Attenuation code, n × 3 dB |
| adapt_active | output | 1 | Adaptation window open and loop not bypassed |

## Verification
The bench drives the flags in adjust cycles only. A design that sampled every cycle would then move the code. It pushes the code into both ends of its range, where a design without saturation would wrap from 7 to 0. It also sets both flags together, and a design that gave the low flag priority would step the wrong way. Restarts are fired while a flag is active, and `tx_mode` is held high for a long time. A design that stepped in the restart cycle, cleared the code on restart, or treated a level as an edge would drift. Finally, clearing bypass after the window has closed exposes a design that reopens the window or forgets the forced value.

// File: rtl/alc_pkg.sv
package alc_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/alc_restart_det.sv
module alc_restart_det (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic tx_mode,
    output logic restart
);
    typedef struct packed {
        logic tx_prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d         = det_q;
        det_d.tx_prev = tx_mode;
        restart       = soft_rst || (tx_mode && !det_q.tx_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    AST_TX_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_mode) |-> restart); // R8

    AST_SOFT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> restart); // R8

endmodule

// File: rtl/alc_window.sv
module alc_window #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic open,
    output logic eval
);
    localparam int CNT_W = $clog2(WINDOW + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        open  = win_q.cnt < CNT_W'(WINDOW);
        eval  = open && !win_q.cnt[0];
        win_d = win_q;
        if (restart)   win_d.cnt = '0;
        else if (open) win_d.cnt = win_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (win_q.cnt == '0)); // R3

    AST_WIN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && open) |=> (win_q.cnt == $past(win_q.cnt) + CNT_W'(1))); // R3

    AST_WIN_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !open) |=> !open); // R10

endmodule

// File: rtl/alc_step.sv
module alc_step
    import alc_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code_in,
    input  step_e             dir,
    output logic [CODE_W-1:0] code_out
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    always_comb begin
        case (dir)
            STEP_UP:   code_out = (code_in == CODE_MAX) ? code_in : code_in + CODE_W'(1);
            STEP_DOWN: code_out = (code_in == '0)       ? code_in : code_in - CODE_W'(1);
            default:   code_out = code_in;
        endcase
    end

endmodule

// File: rtl/tx_alc.sv
module tx_alc
    import alc_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int WINDOW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tx_mode,
    input  logic [CODE_W:0]   ctrl,
    input  logic              lvl_high,
    input  logic              lvl_low,
    output logic [CODE_W-1:0] atten,
    output logic              adapt_active
);
    localparam int BYP_BIT = CODE_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } lvl_t;

    lvl_t              lvl_d, lvl_q;
    logic              restart_w;
    logic              open_w;
    logic              eval_w;
    logic              bypass_w;
    step_e             dir_w;
    logic [CODE_W-1:0] stepped_w;

    alc_restart_det i_restart (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .tx_mode  (tx_mode),
        .restart  (restart_w)
    );

    alc_window #(.WINDOW(WINDOW)) i_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_w),
        .open    (open_w),
        .eval    (eval_w)
    );

    alc_step #(.CODE_W(CODE_W)) i_step (
        .code_in  (lvl_q.code),
        .dir      (dir_w),
        .code_out (stepped_w)
    );

    always_comb begin
        bypass_w = ctrl[BYP_BIT];
        if (lvl_high)     dir_w = STEP_UP;
        else if (lvl_low) dir_w = STEP_DOWN;
        else              dir_w = STEP_HOLD;

        lvl_d = lvl_q;
        if (bypass_w)
            lvl_d.code = ctrl[CODE_W-1:0];
        else if (eval_w && !restart_w)
            lvl_d.code = stepped_w;

        atten        = bypass_w ? ctrl[CODE_W-1:0] : lvl_q.code;
        adapt_active = open_w && !bypass_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    AST_ADJUST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_w && !eval_w) |=> $stable(lvl_q.code)); // R1

    AST_CLOSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_w && !open_w) |=> $stable(lvl_q.code)); // R4

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass_w |=> (lvl_q.code == $past(lvl_q.code)
                    || lvl_q.code == $past(lvl_q.code) + CODE_W'(1)
                    || lvl_q.code == $past(lvl_q.code) - CODE_W'(1))); // R5

    AST_RESTART_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_w && !bypass_w) |=> $stable(lvl_q.code)); // R8

    AST_BYPASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_w |=> (lvl_q.code == $past(ctrl[CODE_W-1:0]))); // R10

endmodule

// File: tb/test_tx_alc.sv
`timescale 1ns/1ps
module test_tx_alc;
    localparam int WIN = 16;

    logic       clk = 1'b0;
    logic       rst_n, soft_rst, tx_mode, lvl_high, lvl_low;
    logic [3:0] ctrl;
    logic [2:0] atten;
    logic       adapt_active;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R7";
    bit    done = 1'b0;

    int m_win, m_code;
    bit m_txp;

    always #2 clk = ~clk;

    tx_alc i_tx_alc (
        .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst), .tx_mode (tx_mode),
        .ctrl (ctrl), .lvl_high (lvl_high), .lvl_low (lvl_low),
        .atten (atten), .adapt_active (adapt_active)
    );

    function automatic int exp_atten();
        return ctrl[3] ? int'(ctrl[2:0]) : m_code;
    endfunction

    function automatic int exp_active();
        return (m_win < WIN && !ctrl[3]) ? 1 : 0;
    endfunction

    task automatic model_reset();
        m_win = 0; m_code = 0; m_txp = 1'b0;
    endtask

    task automatic model_step();
        bit rs, open, ev;
        rs   = soft_rst || (tx_mode && !m_txp);
        open = m_win < WIN;
        ev   = open && (m_win % 2 == 0);
        if (ctrl[3]) m_code = int'(ctrl[2:0]);
        else if (ev && !rs) begin
            if (lvl_high)     m_code = (m_code < 7) ? m_code + 1 : 7;
            else if (lvl_low) m_code = (m_code > 0) ? m_code - 1 : 0;
        end
        if (rs)        m_win = 0;
        else if (open) m_win = m_win + 1;
        m_txp = tx_mode;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(cur_req, "atten", int'(atten), exp_atten());
            chk(cur_req, "adapt_active", int'(adapt_active), exp_active());
            model_step();
            @(posedge clk);
            #1;
        end
    endtask

    task automatic soft_pulse();
        soft_rst = 1'b1;
        cyc(1);
        soft_rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; soft_rst = 1'b0; tx_mode = 1'b0;
        ctrl = 4'b0000; lvl_high = 1'b0; lvl_low = 1'b0;
        model_reset();
        cur_req = "R7";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7", "atten in reset", int'(atten), 0);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk("R7", "atten after release", int'(atten), 0);
        chk("R7", "active after release", int'(adapt_active), 1);

        // Rising code saturates at 7, then frozen
        cur_req = "R5"; lvl_high = 1'b1;
        cyc(20);
        chk("R5", "saturated high", int'(atten), 7);
        cur_req = "R4";
        cyc(10);
        chk("R4", "frozen after window", int'(atten), 7);

        // Soft restart with low flag: restart cycle keeps code
        lvl_high = 1'b0; lvl_low = 1'b1; cur_req = "R8";
        soft_pulse();
        chk("R8", "code kept over soft restart", int'(atten), 7);
        cur_req = "R6";
        cyc(20);
        chk("R6", "saturated low", int'(atten), 0);

        // One-cycle latency of a step
        lvl_low = 1'b0; cur_req = "R2";
        soft_pulse();
        lvl_high = 1'b1;
        cyc(1);
        lvl_high = 1'b0;
        chk("R2", "step visible next cycle", int'(atten), 1);
        cyc(1);
        cur_req = "R6"; lvl_high = 1'b1; lvl_low = 1'b1;
        cyc(2);
        chk("R6", "high flag wins", int'(atten), 2);
        lvl_high = 1'b0; lvl_low = 1'b0;
        cyc(20);

        // Flags only in adjust cycles
        cur_req = "R1";
        soft_pulse();
        for (int i = 0; i < WIN; i++) begin
            lvl_high = (i % 2 == 1);
            cyc(1);
        end
        lvl_high = 1'b0;
        chk("R1", "adjust-cycle flags ignored", int'(atten), 2);

        // Window length
        cur_req = "R3";
        soft_pulse();
        cyc(WIN - 1);
        chk("R3", "active in last window cycle", int'(adapt_active), 1);
        cyc(1);
        chk("R3", "closed after 16 cycles", int'(adapt_active), 0);

        // Transmit entry restart, level held high does not restart
        cur_req = "R8"; lvl_high = 1'b1; tx_mode = 1'b1;
        cyc(1);
        chk("R8", "tx edge keeps code", int'(atten), 2);
        cyc(WIN);
        chk("R8", "stepped to top after tx entry", int'(atten), 7);
        lvl_high = 1'b0; lvl_low = 1'b1;
        cyc(20);
        chk("R8", "held tx_mode no restart", int'(atten), 7);
        tx_mode = 1'b0; lvl_low = 1'b0;
        cyc(2);

        // Bypass
        cur_req = "R9"; ctrl = 4'b1101;
        #0 chk("R9", "forced atten same cycle", int'(atten), 5);
        cyc(3);
        chk("R9", "active off in bypass", int'(adapt_active), 0);
        ctrl = 4'b1010;
        cyc(1);
        chk("R9", "forced atten follows ctrl", int'(atten), 2);

        // Clearing bypass does not reopen window
        cur_req = "R10"; ctrl = 4'b0000; lvl_low = 1'b1;
        cyc(10);
        chk("R10", "code from last forced value", int'(atten), 2);
        chk("R10", "window stays closed", int'(adapt_active), 0);
        soft_pulse();
        cyc(4);
        chk("R10", "resumes from forced value", int'(atten), 0);
        lvl_low = 1'b0;

        // Random mix
        cur_req = "R11";
        for (int i = 0; i < 4000; i++) begin
            soft_rst = ($urandom_range(31) == 0);
            if ($urandom_range(15) == 0) tx_mode = ~tx_mode;
            if ($urandom_range(7) == 0)
                ctrl = {($urandom_range(3) == 0), 3'($urandom_range(7))};
            lvl_high = ($urandom_range(2) == 0);
            lvl_low  = ($urandom_range(1) == 0);
            cyc(1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule